// File: doc/BRIEF.md
# CPU Reset and Halt Hold Sequencer

This block drives the reset and halt lines of a 68000-family processor. It runs from a free-running system clock. After power-up it holds both lines pulled low for a fixed minimum time and then lets them go. The hold can be started again from two other sources. One is a mechanical push-button, which is synchronised and debounced inside the block. The other is a one-cycle request from a host command interface. Whichever source fires, the full hold time runs again from that moment.

The outputs are pull-down enables for open-drain drivers. A 1 on an output means the line is pulled low. A 0 means the line is released and the pull-up, or the processor itself, sets its level. Because of this the processor can still assert its own reset on the shared line.

Hold time and debounce time are given in milliseconds, together with the clock frequency. The block converts them into cycle counts. The hold time is never allowed below 100 ms.

Top module: `rstseq_top`

## Requirements
- R1: Once `rst_ni` is deasserted, `reset_pd_o` and `halt_pd_o` stay 1 for exactly HOLD_CYCLES clock cycles and then go to 0.
- R2: HOLD_CYCLES = max(HOLD_MS, 100) * CLK_HZ / 1000. A HOLD_MS below 100 is raised to 100, so the hold never lasts less than 100 ms.
- R3: `btn_ni` is active low and passes through a two-flop synchroniser. A press counts only after the synchronised level has been low for DB_CYCLES = DEBOUNCE_MS * CLK_HZ / 1000 consecutive samples. Any shorter low pulse is ignored. The outputs go to 1 on the DB_CYCLES+3rd rising edge after `btn_ni` falls.
- R4: A debounced press starts a full HOLD_CYCLES hold. Keeping the button down starts no further hold.
- R5: A one-cycle high on `host_req_i` sets the outputs to 1 from the next cycle, for HOLD_CYCLES cycles.
- R6: A trigger that arrives while a hold is running reloads the full HOLD_CYCLES, counted from that trigger.
- R7: `reset_pd_o` and `halt_pd_o` are equal in every cycle, so they are asserted and released on the same clock edge.
- R8: While `rst_ni` is low, `reset_pd_o`, `halt_pd_o` and `rst_active_o` are all 1 and `release_o` is 0. `rst_active_o` always equals `reset_pd_o`.
- R9: `release_o` is high for exactly one cycle: the first cycle in which the outputs are 0 after a hold.
- R10: Letting go of the button (its debounced level rising) never starts a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| btn_ni | input | 1 | Raw manual reset button, active low, asynchronous |
| host_req_i | input | 1 | One-cycle reset request from the host command interface |
| reset_pd_o | output | 1 | Pull-down enable for the CPU reset line |
| halt_pd_o | output | 1 | Pull-down enable for the CPU halt line |
| rst_active_o | output | 1 | High while a reset hold is running |
| release_o | output | 1 | One-cycle pulse in the first cycle after the hold ends |

## Verification
Each fault in the hold counter shows up at the outputs as a release on the wrong cycle:
- A wrong reload value or a wrong decrement makes the hold longer or shorter than HOLD_CYCLES.
- A missed reload on a retrigger makes the lines release early.

Each such error becomes visible a whole hold length after the trigger, so the hold is measured cycle by cycle.

Debouncer faults show up much sooner:
- Accepting a short glitch asserts the outputs within DB_CYCLES+3 cycles.
- Acting on a button release asserts the outputs within DB_CYCLES+3 cycles of the release.
- A wrong press latency is seen directly when the outputs first go high.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int unsigned MIN_HOLD_MS = 100;

  function automatic int unsigned ms_to_cycles(int unsigned clk_hz, int unsigned ms);
    longint unsigned prod;
    prod = 64'(clk_hz) * 64'(ms) / 64'd1000;
    if (prod < 64'd1) prod = 64'd1;
    return int'(prod);
  endfunction

  function automatic int unsigned clamp_hold_ms(int unsigned ms);
    return (ms < MIN_HOLD_MS) ? MIN_HOLD_MS : ms;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstseq_debounce.sv
module rstseq_debounce #(
  parameter int unsigned DB_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_ni,
  output logic press_o
);
  localparam int unsigned CW = $clog2(DB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          stable_q;
  logic          press_q;
  logic          differ;
  logic          accept;

  assign differ = (level_ni != stable_q);
  assign accept = differ && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b1;
      press_q  <= 1'b0;
    end else begin
      // only a new low level counts as a press; rising level is dropped
      press_q <= accept && !level_ni;
      if (!differ) begin
        cnt_q <= '0;
      end else if (accept) begin
        cnt_q    <= '0;
        stable_q <= level_ni;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/rstseq_hold.sv
module rstseq_hold #(
  parameter int unsigned HOLD_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic reset_pd_o,
  output logic halt_pd_o,
  output logic release_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          rst_pd_q, halt_pd_q, rel_q;

  always_comb begin
    if (trig_i)            cnt_n = FULL;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
    else                   cnt_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= FULL;
      rst_pd_q  <= 1'b1;
      halt_pd_q <= 1'b1;
      rel_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      rst_pd_q  <= (cnt_n != '0);
      halt_pd_q <= (cnt_n != '0);
      rel_q     <= (cnt_q != '0) && (cnt_n == '0);
    end
  end

  assign reset_pd_o = rst_pd_q;
  assign halt_pd_o  = halt_pd_q;
  assign release_o  = rel_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 8_000_000,
  parameter int unsigned HOLD_MS     = 100,
  parameter int unsigned DEBOUNCE_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic host_req_i,
  output logic reset_pd_o,
  output logic halt_pd_o,
  output logic rst_active_o,
  output logic release_o
);
  localparam int unsigned HOLD_CYCLES = ms_to_cycles(CLK_HZ, clamp_hold_ms(HOLD_MS));
  localparam int unsigned DB_CYCLES   = ms_to_cycles(CLK_HZ, DEBOUNCE_MS);

  logic btn_sync_n;
  logic press;
  logic trig;

  rstseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_ni),
    .q_o   (btn_sync_n)
  );

  rstseq_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_ni(btn_sync_n),
    .press_o (press)
  );

  assign trig = press | host_req_i;

  rstseq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .reset_pd_o(reset_pd_o),
    .halt_pd_o (halt_pd_o),
    .release_o (release_o)
  );

  assign rst_active_o = reset_pd_o;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int unsigned CLK_HZ = 8_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic host_req_i,
  input logic reset_pd_o,
  input logic halt_pd_o,
  input logic rst_active_o,
  input logic release_o
);
  localparam longint unsigned FLOOR = 64'(CLK_HZ) / 64'd10;

  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (reset_pd_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  p_lines_equal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_pd_o == halt_pd_o);

  p_status_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active_o == reset_pd_o);

  p_release_after_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (!reset_pd_o && $past(reset_pd_o)));

  p_release_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !release_o);

  p_host_starts_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |=> reset_pd_o);

  p_min_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_pd_o && run_q != 0) |-> (64'(run_q) >= FLOOR));
endmodule

bind rstseq_top rstseq_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_req_i  (host_req_i),
  .reset_pd_o  (reset_pd_o),
  .halt_pd_o   (halt_pd_o),
  .rst_active_o(rst_active_o),
  .release_o   (release_o)
);

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
  localparam int CLK_HZ = 10_000;
  localparam int H      = 1000;  // 100 ms at 10 kHz
  localparam int DB     = 100;   // 10 ms at 10 kHz

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic host_req = 1'b0;
  logic rpd, hpd, act, rel;
  logic rpd_b, hpd_b, act_b, rel_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rstseq_top #(.CLK_HZ(CLK_HZ), .HOLD_MS(100), .DEBOUNCE_MS(10)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .host_req_i(host_req),
    .reset_pd_o(rpd), .halt_pd_o(hpd), .rst_active_o(act), .release_o(rel)
  );

  // hold below the floor must be raised to 100 ms
  rstseq_top #(.CLK_HZ(CLK_HZ), .HOLD_MS(20), .DEBOUNCE_MS(10)) u_dut_clamp (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(1'b1), .host_req_i(1'b0),
    .reset_pd_o(rpd_b), .halt_pd_o(hpd_b), .rst_active_o(act_b), .release_o(rel_b)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // counts negedge samples with the hold active, starting at the current time
  task automatic count_hold(output int n, output int mism);
    n = 0; mism = 0;
    while (act && n < 4*H) begin
      if (rpd != hpd) mism++;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic host_pulse();
    @(negedge clk); host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
  endtask

  task automatic quiet_window(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (act || rpd || hpd) hits++;
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(rpd == 1'b1, "R8 reset_pd in reset", rpd, 1);
    check(hpd == 1'b1, "R8 halt_pd in reset", hpd, 1);
    check(act == 1'b1, "R8 active in reset", act, 1);
    check(rel == 1'b0, "R8 release in reset", rel, 0);
  endtask

  task automatic t_power_on();
    int na = 0, nb = 0, mism = 0;
    rst_n = 1'b1;
    while ((act || act_b) && na < 4*H) begin
      if (act) na++;
      if (act_b) nb++;
      if (rpd != hpd) mism++;
      @(negedge clk);
    end
    check(na == H, "R1 power-on hold", na, H);
    check(nb == H, "R2 clamped hold", nb, H);
    check(mism == 0, "R7 lines differ", mism, 0);
    check(rel == 1'b1, "R9 release pulse", rel, 1);
    @(negedge clk);
    check(rel == 1'b0, "R9 release one cycle", rel, 0);
  endtask

  task automatic t_host();
    int n, m;
    host_pulse();
    check(act == 1'b1, "R5 host asserts next cycle", act, 1);
    count_hold(n, m);
    check(n == H, "R5 host hold length", n, H);
    check(m == 0, "R7 lines differ host", m, 0);
    check(rel == 1'b1, "R9 release after host hold", rel, 1);
  endtask

  task automatic t_retrigger();
    int n, m;
    host_pulse();
    repeat (300) @(negedge clk);
    host_pulse();
    count_hold(n, m);
    check(n == H, "R6 reload on retrigger", n, H);
  endtask

  task automatic t_glitch();
    int hits;
    repeat (5) @(negedge clk);
    btn_n = 1'b0;
    repeat (DB - 1) @(negedge clk);
    btn_n = 1'b1;
    quiet_window(2*DB + 10, hits);
    check(hits == 0, "R3 short glitch ignored", hits, 0);
  endtask

  task automatic t_button();
    int k = 0, n, m, hits;
    @(negedge clk);
    btn_n = 1'b0;
    while (!act && k < 4*DB) begin
      @(negedge clk);
      k++;
    end
    check(k == DB + 3, "R3 press latency", k, DB + 3);
    count_hold(n, m);
    check(n == H, "R4 button hold length", n, H);
    quiet_window(300, hits);
    check(hits == 0, "R4 held button single hold", hits, 0);
    btn_n = 1'b1;
    quiet_window(2*DB + 10, hits);
    check(hits == 0, "R10 button release no hold", hits, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_power_on();
    t_host();
    t_retrigger();
    t_glitch();
    t_button();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule